// File: doc/BRIEF.md
# MD5 Compression Core

This block runs the MD5 compression function over a stream of 512-bit message blocks that have already been padded and split into little-endian 32-bit words. One step of the algorithm is evaluated per clock on a single shared step datapath: the round function changes every sixteen steps, and a message-word selector, an additive-constant table and a rotate-amount table are all indexed by the step counter. After the 64th step, a feed-forward cycle adds the working words back into the chaining value.

A block is offered with `blk_valid` and is taken when `blk_ready` is high. Two flags travel with the block. `blk_first` restarts the chain from the standard initial value. `blk_last` marks the final block of a message. When the last block has been folded, the core raises `dig_done` for one cycle and updates `digest`. A message of several blocks is sent as a run of blocks in which only the first carries `blk_first` and only the final one carries `blk_last`.

Top module: `md5_core`

## Requirements
- R1: After reset, `blk_ready` is 1, `dig_done` is 0 and `digest` is all zeros.
- R2: A block is taken on a rising edge where `blk_valid` and `blk_ready` are both 1. `blk_ready` is then low for exactly 65 cycles and returns high on the 65th edge after the accepting edge.
- R3: Message word i of a block is `blk_data[32*i+31:32*i]`, already in little-endian word form. A block with `blk_first`=1 starts from a=0x67452301, b=0xefcdab89, c=0x98badcfe, d=0x10325476. The padded empty message (word 0 = 0x00000080, all other words 0) gives digest 0xd41d8cd98f00b204e9800998ecf8427e.
- R4: Each of the 64 steps sets the new b to b + rotl(a + fn(b,c,d) + m[k] + K, s) modulo 2^32, with (a,b,c,d) then becoming (d, new, b, c). The four quarters use, in turn: fn = (b&c)|(~b&d) with k=j; fn = (b&d)|(c&~d) with k=(5j+1) mod 16; fn = b^c^d with k=(3j+5) mod 16; and fn = c^(b|~d) with k=7j mod 16. The rotate amounts cycle through 7,12,17,22 / 5,9,14,20 / 4,11,16,23 / 6,10,15,21. K for step t (counted from 0) is floor(2^32·|sin(t+1)|).
- R5: After the 64 steps, each chaining word becomes its value before the block plus the final working word, modulo 2^32. A block with `blk_first`=0 continues from the chaining value left by the previous block, or from the initial value if no block has been folded since reset.
- R6: After a block with `blk_last`=1, `dig_done` is high for exactly one cycle, on the same edge at which `blk_ready` returns. `digest` then holds a‖b‖c‖d with each word in byte-reversed order, so `digest[127:120]` is the low byte of a.
- R7: `digest` changes only on the edge that raises `dig_done`. A block with `blk_last`=0 neither pulses `dig_done` nor alters `digest`.
- R8: `blk_first`=1 discards any chain in progress. The result depends only on the blocks from that block onward.
- R9: A new block can be accepted in the same cycle in which `dig_done` is high.
- R10: While `blk_valid` is low in the idle state, the outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_valid | input | 1 | A block is offered |
| blk_ready | output | 1 | Core is idle and can take a block |
| blk_first | input | 1 | Block starts a new message |
| blk_last | input | 1 | Block ends the message |
| blk_data | input | 512 | Sixteen little-endian message words, word i at bits 32i+31:32i |
| dig_done | output | 1 | One-cycle pulse when a digest is ready |
| digest | output | 128 | Message digest, byte order as R6 |

## Verification
The digest output pulse and the acceptance of the next block can fall in the same cycle, because `blk_ready` returns on the same edge that raises `dig_done`. The bench provokes this by presenting a new block at the very sample point where it first sees the done pulse. It then judges three things: the digest shown in that cycle still belongs to the finished message, the core goes busy on the next edge, and the following message's digest matches an arithmetic model of the compression function. Chains of one to three random blocks, together with the two known single-block digests, exercise the chaining and the feed-forward around this overlap.

// File: rtl/md5_core.sv
module md5_core (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         blk_valid,
  output logic         blk_ready,
  input  logic         blk_first,
  input  logic         blk_last,
  input  logic [511:0] blk_data,
  output logic         dig_done,
  output logic [127:0] digest
);
  localparam int W     = 32;
  localparam int STEPS = 64;
  localparam logic [W-1:0] IV_A = 32'h67452301;
  localparam logic [W-1:0] IV_B = 32'hefcdab89;
  localparam logic [W-1:0] IV_C = 32'h98badcfe;
  localparam logic [W-1:0] IV_D = 32'h10325476;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FOLD} st_t;

  st_t          st;
  logic [5:0]   step;
  logic [W-1:0] wa, wb, wc, wd, ha, hb, hc, hd;
  logic [511:0] msg;
  logic         last_q;

  function automatic logic [W-1:0] kconst(input logic [5:0] t);
    case (t)
      6'd0:  kconst = 32'hd76aa478; 6'd1:  kconst = 32'he8c7b756;
      6'd2:  kconst = 32'h242070db; 6'd3:  kconst = 32'hc1bdceee;
      6'd4:  kconst = 32'hf57c0faf; 6'd5:  kconst = 32'h4787c62a;
      6'd6:  kconst = 32'ha8304613; 6'd7:  kconst = 32'hfd469501;
      6'd8:  kconst = 32'h698098d8; 6'd9:  kconst = 32'h8b44f7af;
      6'd10: kconst = 32'hffff5bb1; 6'd11: kconst = 32'h895cd7be;
      6'd12: kconst = 32'h6b901122; 6'd13: kconst = 32'hfd987193;
      6'd14: kconst = 32'ha679438e; 6'd15: kconst = 32'h49b40821;
      6'd16: kconst = 32'hf61e2562; 6'd17: kconst = 32'hc040b340;
      6'd18: kconst = 32'h265e5a51; 6'd19: kconst = 32'he9b6c7aa;
      6'd20: kconst = 32'hd62f105d; 6'd21: kconst = 32'h02441453;
      6'd22: kconst = 32'hd8a1e681; 6'd23: kconst = 32'he7d3fbc8;
      6'd24: kconst = 32'h21e1cde6; 6'd25: kconst = 32'hc33707d6;
      6'd26: kconst = 32'hf4d50d87; 6'd27: kconst = 32'h455a14ed;
      6'd28: kconst = 32'ha9e3e905; 6'd29: kconst = 32'hfcefa3f8;
      6'd30: kconst = 32'h676f02d9; 6'd31: kconst = 32'h8d2a4c8a;
      6'd32: kconst = 32'hfffa3942; 6'd33: kconst = 32'h8771f681;
      6'd34: kconst = 32'h6d9d6122; 6'd35: kconst = 32'hfde5380c;
      6'd36: kconst = 32'ha4beea44; 6'd37: kconst = 32'h4bdecfa9;
      6'd38: kconst = 32'hf6bb4b60; 6'd39: kconst = 32'hbebfbc70;
      6'd40: kconst = 32'h289b7ec6; 6'd41: kconst = 32'heaa127fa;
      6'd42: kconst = 32'hd4ef3085; 6'd43: kconst = 32'h04881d05;
      6'd44: kconst = 32'hd9d4d039; 6'd45: kconst = 32'he6db99e5;
      6'd46: kconst = 32'h1fa27cf8; 6'd47: kconst = 32'hc4ac5665;
      6'd48: kconst = 32'hf4292244; 6'd49: kconst = 32'h432aff97;
      6'd50: kconst = 32'hab9423a7; 6'd51: kconst = 32'hfc93a039;
      6'd52: kconst = 32'h655b59c3; 6'd53: kconst = 32'h8f0ccc92;
      6'd54: kconst = 32'hffeff47d; 6'd55: kconst = 32'h85845dd1;
      6'd56: kconst = 32'h6fa87e4f; 6'd57: kconst = 32'hfe2ce6e0;
      6'd58: kconst = 32'ha3014314; 6'd59: kconst = 32'h4e0811a1;
      6'd60: kconst = 32'hf7537e82; 6'd61: kconst = 32'hbd3af235;
      6'd62: kconst = 32'h2ad7d2bb; default: kconst = 32'heb86d391;
    endcase
  endfunction

  function automatic logic [4:0] rotamt(input logic [3:0] sel);
    case (sel)
      4'h0: rotamt = 5'd7;  4'h1: rotamt = 5'd12; 4'h2: rotamt = 5'd17; 4'h3: rotamt = 5'd22;
      4'h4: rotamt = 5'd5;  4'h5: rotamt = 5'd9;  4'h6: rotamt = 5'd14; 4'h7: rotamt = 5'd20;
      4'h8: rotamt = 5'd4;  4'h9: rotamt = 5'd11; 4'ha: rotamt = 5'd16; 4'hb: rotamt = 5'd23;
      4'hc: rotamt = 5'd6;  4'hd: rotamt = 5'd10; 4'he: rotamt = 5'd15; default: rotamt = 5'd21;
    endcase
  endfunction

  function automatic logic [W-1:0] bswap(input logic [W-1:0] x);
    bswap = {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  logic [1:0]   rnd;
  logic [3:0]   j, kidx;
  logic [W-1:0] fval, mword, sum, rot, anew;
  logic [63:0]  dbl;
  logic [4:0]   sh;
  logic [W-1:0] na, nb, nc, nd;

  assign rnd = step[5:4];
  assign j   = step[3:0];

  always_comb begin
    case (rnd)
      2'd0: begin fval = (wb & wc) | (~wb & wd); kidx = j;                 end
      2'd1: begin fval = (wb & wd) | (wc & ~wd); kidx = j * 4'd5 + 4'd1;   end
      2'd2: begin fval = wb ^ wc ^ wd;           kidx = j * 4'd3 + 4'd5;   end
      default: begin fval = wc ^ (wb | ~wd);     kidx = j * 4'd7;          end
    endcase
  end

  assign mword = msg[kidx*W +: W];
  assign sh    = rotamt({rnd, step[1:0]});
  assign sum   = wa + fval + mword + kconst(step);
  assign dbl   = {sum, sum} << sh;
  assign rot   = dbl[63:32];
  assign anew  = wb + rot;

  assign na = ha + wa;
  assign nb = hb + wb;
  assign nc = hc + wc;
  assign nd = hd + wd;

  assign blk_ready = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; step <= '0; last_q <= 1'b0; msg <= '0;
      wa <= '0; wb <= '0; wc <= '0; wd <= '0;
      ha <= IV_A; hb <= IV_B; hc <= IV_C; hd <= IV_D;
      dig_done <= 1'b0; digest <= '0;
    end else begin
      dig_done <= 1'b0;
      case (st)
        S_IDLE: if (blk_valid) begin
          msg <= blk_data; last_q <= blk_last; step <= '0; st <= S_RUN;
          if (blk_first) begin
            wa <= IV_A; wb <= IV_B; wc <= IV_C; wd <= IV_D;
            ha <= IV_A; hb <= IV_B; hc <= IV_C; hd <= IV_D;
          end else begin
            wa <= ha; wb <= hb; wc <= hc; wd <= hd;
          end
        end
        S_RUN: begin
          wa <= wd; wb <= anew; wc <= wb; wd <= wc;
          step <= step + 6'd1;
          if (step == 6'(STEPS - 1)) st <= S_FOLD;
        end
        default: begin
          ha <= na; hb <= nb; hc <= nc; hd <= nd;
          if (last_q) begin
            digest <= {bswap(na), bswap(nb), bswap(nc), bswap(nd)};
            dig_done <= 1'b1;
          end
          st <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/md5_core_chk.sv
module md5_core_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         blk_valid,
  input logic         blk_ready,
  input logic         dig_done,
  input logic [127:0] digest
);
  logic [6:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else if (blk_valid && blk_ready) busy_cnt <= '0;
    else if (!blk_ready) busy_cnt <= busy_cnt + 7'd1;
  end

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && blk_ready |=> !blk_ready);

  p_ready_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_ready) |-> busy_cnt == 7'd65);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dig_done |=> !dig_done);

  p_done_with_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dig_done |-> blk_ready);

  p_digest_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dig_done |=> ($stable(digest) || dig_done));
endmodule

bind md5_core md5_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_ready(blk_ready),
  .dig_done(dig_done), .digest(digest)
);

// File: tb/md5_core_tb.sv
`timescale 1ns/1ps
module md5_core_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         blk_valid = 1'b0, blk_first = 1'b0, blk_last = 1'b0;
  logic [511:0] blk_data = '0;
  logic         blk_ready, dig_done;
  logic [127:0] digest;
  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  md5_core u_dut (.clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_ready(blk_ready),
    .blk_first(blk_first), .blk_last(blk_last), .blk_data(blk_data),
    .dig_done(dig_done), .digest(digest));

  localparam logic [127:0] IV = {32'h67452301, 32'hefcdab89, 32'h98badcfe, 32'h10325476};

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] kgen(input int t);
    real x;
    longint v;
    x = $sin(real'(t + 1));
    if (x < 0.0) x = -x;
    v = longint'($floor(x * 4294967296.0));
    return v[31:0];
  endfunction

  function automatic logic [127:0] model(input logic [127:0] hin, input logic [511:0] m);
    int sh[16] = '{7,12,17,22, 5,9,14,20, 4,11,16,23, 6,10,15,21};
    logic [31:0] a, b, c, d, f, t;
    int k, r, jj, s;
    a = hin[127:96]; b = hin[95:64]; c = hin[63:32]; d = hin[31:0];
    for (int i = 0; i < 64; i++) begin
      r = i / 16; jj = i % 16;
      case (r)
        0: begin f = (b & c) | (~b & d); k = jj; end
        1: begin f = (b & d) | (c & ~d); k = (5*jj + 1) % 16; end
        2: begin f = b ^ c ^ d;          k = (3*jj + 5) % 16; end
        default: begin f = c ^ (b | ~d); k = (7*jj) % 16; end
      endcase
      s = sh[r*4 + i%4];
      t = a + f + m[32*k +: 32] + kgen(i);
      t = (t << s) | (t >> (32 - s));
      t = b + t;
      a = d; d = c; c = b; b = t;
    end
    return {hin[127:96] + a, hin[95:64] + b, hin[63:32] + c, hin[31:0] + d};
  endfunction

  function automatic logic [127:0] to_digest(input logic [127:0] h);
    logic [127:0] o;
    for (int w = 0; w < 4; w++)
      for (int by = 0; by < 4; by++)
        o[127 - 32*w - 8*by -: 8] = h[127 - 32*w - 24 + 8*by -: 8];
    return o;
  endfunction

  function automatic logic [511:0] rnd_block();
    logic [511:0] b;
    for (int w = 0; w < 16; w++) b[32*w +: 32] = $urandom;
    return b;
  endfunction

  // Called at a negedge where blk_ready is high; returns at the negedge where it is high again.
  task automatic run_block(input logic [511:0] d, input bit f, input bit l, output bit got_done, output int lat);
    blk_data = d; blk_first = f; blk_last = l; blk_valid = 1'b1;
    @(posedge clk); #1; blk_valid = 1'b0;
    lat = 0;
    @(negedge clk);
    check(blk_ready == 1'b0, "R2 busy after accept", 128'(blk_ready), 128'd0);
    while (!blk_ready && lat < 300) begin @(negedge clk); lat++; end
    got_done = dig_done;
    check(lat == 65, "R2 ready latency", 128'(lat), 128'd65);
  endtask

  initial begin
    #1_500_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [511:0] blk, blk_empty, blk_abc;
    logic [127:0] h, prev, exp_d;
    bit gd;
    int lat, nb;
    blk_empty = '0; blk_empty[31:0] = 32'h00000080;
    blk_abc = '0; blk_abc[31:0] = 32'h80636261; blk_abc[14*32 +: 32] = 32'd24;

    repeat (3) @(negedge clk);
    check(blk_ready == 1'b1, "R1 ready in reset", 128'(blk_ready), 128'd1);
    check(dig_done == 1'b0, "R1 done in reset", 128'(dig_done), 128'd0);
    check(digest == '0, "R1 digest in reset", digest, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: idle with valid low
    repeat (20) @(negedge clk);
    check(blk_ready && !dig_done && digest == '0, "R10 idle no change", digest, 128'd0);

    // R3, R6: empty message
    run_block(blk_empty, 1'b1, 1'b1, gd, lat);
    check(gd == 1'b1, "R6 done pulse", 128'(gd), 128'd1);
    check(digest == 128'hd41d8cd98f00b204e9800998ecf8427e, "R3 empty digest", digest, 128'hd41d8cd98f00b204e9800998ecf8427e);
    @(negedge clk);
    check(dig_done == 1'b0, "R6 single-cycle pulse", 128'(dig_done), 128'd0);

    // R4 and R9: "abc", then a new block in the done cycle
    run_block(blk_abc, 1'b1, 1'b1, gd, lat);
    check(gd == 1'b1 && digest == 128'h900150983cd24fb0d6963f7d28e17f72, "R4 abc digest", digest, 128'h900150983cd24fb0d6963f7d28e17f72);
    blk = rnd_block();
    run_block(blk, 1'b1, 1'b1, gd, lat);
    exp_d = to_digest(model(IV, blk));
    check(gd == 1'b1 && digest == exp_d, "R9 block accepted in done cycle", digest, exp_d);

    // R5, R7: sweep of multi-block chains, each started in the previous done cycle
    for (int msgn = 0; msgn < 40; msgn++) begin
      nb = 1 + (msgn % 3);
      h = IV;
      for (int bi = 0; bi < nb; bi++) begin
        blk = rnd_block();
        h = model(h, blk);
        prev = digest;
        run_block(blk, bi == 0, bi == nb - 1, gd, lat);
        if (bi != nb - 1) begin
          check(!gd && digest == prev, "R7 no output on non-last block", digest, prev);
        end else begin
          exp_d = to_digest(h);
          check(gd && digest == exp_d, "R5 chained digest", digest, exp_d);
        end
      end
    end

    // R8: restart mid-chain
    blk = rnd_block();
    run_block(blk, 1'b1, 1'b0, gd, lat);
    run_block(rnd_block(), 1'b0, 1'b0, gd, lat);
    run_block(blk_empty, 1'b1, 1'b1, gd, lat);
    check(digest == 128'hd41d8cd98f00b204e9800998ecf8427e, "R8 restart discards chain", digest, 128'hd41d8cd98f00b204e9800998ecf8427e);

    // R5: continuing chain without first flag after a completed message
    blk = rnd_block();
    h = model(model(IV, blk_empty), blk);
    run_block(blk, 1'b0, 1'b1, gd, lat);
    exp_d = to_digest(h);
    check(digest == exp_d, "R5 chain continues without first", digest, exp_d);

    // R10: held idle again, digest unchanged
    prev = digest;
    repeat (10) @(negedge clk);
    check(blk_ready && !dig_done && digest == prev, "R10 idle keeps digest", digest, prev);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule